// File: doc/BRIEF.md
# BCD Fractional Phase Accumulator

This block sits in the digital part of a fractional-step synthesizer loop. On every strobe from the 100 kHz reference, which marks a 10 µs frame, it works out how many oscillator cycles fall due in that frame. It then adds that amount to a running phase total. The programmed output frequency arrives as a packed BCD word. Frequency multiplied by 10 µs splits into two parts. The whole-cycle part goes to the loop divider as a cycle count. The decimal fraction of a cycle builds up frame by frame and is shown as a residue, which drives a phase-error correction generator.

All arithmetic is decimal. The phase register keeps an integer part and a five-digit fractional part, each held as BCD digits. Each digit is added by a ripple of single-digit adders, and each digit adder applies the +6 correction. When the fractional total passes one whole cycle, the extra cycle is added to the count issued for that frame. Over many frames this gives an average frequency resolution of 1 Hz, far finer than the 100 kHz reference step.

Top module: `bcd_phase_accum`

## Requirements
- R1: A synchronous active-high `rst` sets `cycles`, `phase_int`, `residue` and the held frequency word to zero. If a strobe follows without a load, the increment it adds is zero.
- R2: The state changes only in a cycle where `frame` is high. The new `cycles`, `phase_int` and `residue` appear on the clock edge that samples the strobe. In all other cycles they hold their values, whatever happens on `freq_word`.
- R3: `freq_word` holds eight BCD digits. Bits [31:28] are tens of MHz and bits [3:0] are Hz. The top three digits give the whole cycles per frame (frequency / 100 kHz). The low five digits give the fraction of a cycle in units of 1e-5. So 42.000001 MHz adds 420 cycles plus 0.00001 of a cycle.
- R4: `freq_word` is captured only when `load` and `frame` are both high in the same cycle, and it already sets that frame's increment. A `load` without `frame` has no effect.
- R5: `residue` is the stored fraction of phase, as five BCD digits. Starting from zero at 42.123000 MHz, it reads 23000, 46000, 69000, 92000, 15000 after each frame.
- R6: If the fractional sum reaches or passes 1.00000, it wraps modulo one, and `cycles` for that frame is the whole-cycle part plus one. Otherwise `cycles` equals the whole-cycle part. For 42.15 MHz the count alternates 421, 422.
- R7: `phase_int` is the running total of issued cycles, modulo 10^4, as four BCD digits. For 42.123 MHz it reads 421, 842, 1263, 1684, 2106.
- R8: Every 4-bit digit of `cycles`, `phase_int` and `residue` stays in 0..9, and the top digit of `cycles` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame | input | 1 | One-cycle strobe per 10 µs reference frame |
| load | input | 1 | Take `freq_word` at this frame |
| freq_word | input | 32 | Output frequency, 8 BCD digits, 10 MHz down to 1 Hz |
| cycles | output | 16 | Whole cycles due this frame, 4 BCD digits |
| phase_int | output | 16 | Integer phase total, 4 BCD digits |
| residue | output | 20 | Fractional phase, 5 BCD digits (units of 1e-5 cycle) |

## Verification
The bench builds the block with its default parameters: three integer digits, five fraction digits and a four-digit phase register. At these sizes a 70 MHz word wraps the integer phase within fifteen frames, and a word one digit above the Hz boundary steps the residue by its least significant unit. With these parameters both digit ends of each adder chain, the fraction-to-count carry and the modulo wrap of the phase total are all reachable in a few hundred cycles. Random words across the 42 to 70 MHz range are also applied, with load on or off, and they cross digit carries throughout the chains.

// File: rtl/bcd_phase_pkg.sv
package bcd_phase_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] bcd_t;
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_phase_pkg::*;
(
  input  bcd_t a,
  input  bcd_t b,
  input  logic ci,
  output bcd_t s,
  output logic co
);
  logic [DIG_W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b} + {{DIG_W{1'b0}}, ci};
    co  = (raw > 5'd9);
    // decimal adjust: skip the six unused codes
    s   = raw[DIG_W-1:0] + (co ? 4'd6 : 4'd0);
  end
endmodule

// File: rtl/bcd_word_add.sv
module bcd_word_add
  import bcd_phase_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [DIGITS*DIG_W-1:0] a,
  input  logic [DIGITS*DIG_W-1:0] b,
  input  logic                    cin,
  output logic [DIGITS*DIG_W-1:0] sum,
  output logic                    cout
);
  logic [DIGITS:0] carry;

  assign carry[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcd_digit_add u_dig (
      .a  (a[g*DIG_W +: DIG_W]),
      .b  (b[g*DIG_W +: DIG_W]),
      .ci (carry[g]),
      .s  (sum[g*DIG_W +: DIG_W]),
      .co (carry[g+1])
    );
  end

  assign cout = carry[DIGITS];
endmodule

// File: rtl/bcd_phase_accum.sv
module bcd_phase_accum
  import bcd_phase_pkg::*;
#(
  parameter int INT_DIGITS  = 3,
  parameter int FRAC_DIGITS = 5,
  parameter int PH_DIGITS   = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   frame,
  input  logic                                   load,
  input  logic [(INT_DIGITS+FRAC_DIGITS)*4-1:0]  freq_word,
  output logic [(INT_DIGITS+1)*4-1:0]            cycles,
  output logic [PH_DIGITS*4-1:0]                 phase_int,
  output logic [FRAC_DIGITS*4-1:0]               residue
);
  localparam int WORD_W = (INT_DIGITS + FRAC_DIGITS) * DIG_W;
  localparam int INT_W  = INT_DIGITS * DIG_W;
  localparam int FRAC_W = FRAC_DIGITS * DIG_W;
  localparam int PH_W   = PH_DIGITS * DIG_W;
  localparam int CYC_W  = (INT_DIGITS + 1) * DIG_W;

  logic [WORD_W-1:0] act_q;
  logic [WORD_W-1:0] inc_word;
  logic [INT_W-1:0]  inc_int;
  logic [FRAC_W-1:0] inc_frac;
  logic [FRAC_W-1:0] frac_nxt;
  logic              frac_c;
  logic [INT_W-1:0]  cnt_lo;
  logic              cnt_c;
  logic [CYC_W-1:0]  cnt_nxt;
  logic [PH_W-1:0]   ph_nxt;
  logic              ph_wrap;

  // A word on the port counts from the very frame that loads it
  assign inc_word = load ? freq_word : act_q;
  assign inc_int  = inc_word[WORD_W-1 -: INT_W];
  assign inc_frac = inc_word[FRAC_W-1:0];

  bcd_word_add #(.DIGITS(FRAC_DIGITS)) u_frac_add (
    .a    (residue),
    .b    (inc_frac),
    .cin  (1'b0),
    .sum  (frac_nxt),
    .cout (frac_c)
  );

  bcd_word_add #(.DIGITS(INT_DIGITS)) u_cnt_add (
    .a    (inc_int),
    .b    ({INT_W{1'b0}}),
    .cin  (frac_c),
    .sum  (cnt_lo),
    .cout (cnt_c)
  );

  assign cnt_nxt = {{(DIG_W-1){1'b0}}, cnt_c, cnt_lo};

  bcd_word_add #(.DIGITS(PH_DIGITS)) u_ph_add (
    .a    (phase_int),
    .b    (PH_W'(inc_int)),
    .cin  (frac_c),
    .sum  (ph_nxt),
    .cout (ph_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= '0;
      cycles    <= '0;
      phase_int <= '0;
      residue   <= '0;
    end else if (frame) begin
      act_q     <= inc_word;
      cycles    <= cnt_nxt;
      phase_int <= ph_nxt;
      residue   <= frac_nxt;
    end
  end
endmodule

// File: rtl/bcd_phase_accum_chk.sv
module bcd_phase_accum_chk #(
  parameter int INT_DIGITS  = 3,
  parameter int FRAC_DIGITS = 5,
  parameter int PH_DIGITS   = 4
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  frame,
  input logic                                  load,
  input logic [(INT_DIGITS+FRAC_DIGITS)*4-1:0] act_word,
  input logic                                  ph_wrap,
  input logic [(INT_DIGITS+1)*4-1:0]           cycles,
  input logic [PH_DIGITS*4-1:0]                phase_int,
  input logic [FRAC_DIGITS*4-1:0]              residue
);
  localparam int CYC_W = (INT_DIGITS + 1) * 4;

  function automatic bit digits_ok(input logic [CYC_W-1:0] c,
                                   input logic [PH_DIGITS*4-1:0] p,
                                   input logic [FRAC_DIGITS*4-1:0] r);
    bit ok = 1'b1;
    for (int i = 0; i < INT_DIGITS + 1; i++) if (c[i*4 +: 4] > 4'd9) ok = 1'b0;
    for (int i = 0; i < PH_DIGITS; i++)      if (p[i*4 +: 4] > 4'd9) ok = 1'b0;
    for (int i = 0; i < FRAC_DIGITS; i++)    if (r[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cycles == '0 && phase_int == '0 && residue == '0 && act_word == '0));

  a_r2_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
    !frame |=> ($stable(cycles) && $stable(phase_int) && $stable(residue)));

  a_r4_word_only_on_load_frame: assert property (@(posedge clk) disable iff (rst)
    !(frame && load) |=> $stable(act_word));

  a_r7_wrap_goes_down: assert property (@(posedge clk) disable iff (rst)
    (frame && ph_wrap) |=> (phase_int < $past(phase_int)));

  a_r7_no_wrap_goes_up: assert property (@(posedge clk) disable iff (rst)
    (frame && !ph_wrap) |=> (phase_int >= $past(phase_int)));

  a_r8_valid_digits: assert property (@(posedge clk) disable iff (rst)
    digits_ok(cycles, phase_int, residue));

  a_r8_count_top_digit: assert property (@(posedge clk) disable iff (rst)
    cycles[CYC_W-1 -: 4] <= 4'd1);
endmodule

bind bcd_phase_accum bcd_phase_accum_chk #(
  .INT_DIGITS (INT_DIGITS),
  .FRAC_DIGITS(FRAC_DIGITS),
  .PH_DIGITS  (PH_DIGITS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .frame    (frame),
  .load     (load),
  .act_word (act_q),
  .ph_wrap  (ph_wrap),
  .cycles   (cycles),
  .phase_int(phase_int),
  .residue  (residue)
);

// File: tb/bcd_phase_accum_test.sv
module bcd_phase_accum_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame = 1'b0;
  logic        load = 1'b0;
  logic [31:0] freq_word = '0;
  logic [15:0] cycles;
  logic [15:0] phase_int;
  logic [19:0] residue;

  always #5 clk = ~clk;

  bcd_phase_accum uut (
    .clk(clk), .rst(rst), .frame(frame), .load(load), .freq_word(freq_word),
    .cycles(cycles), .phase_int(phase_int), .residue(residue)
  );

  typedef struct { int cyc; int pint; int frac; string tag; } exp_t;
  exp_t q[$];

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_hz = 0;
  int m_frac = 0;
  int m_pint = 0;
  int m_cyc = 0;

  function automatic int bcd2int(input logic [31:0] v, input int nd);
    int r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
    return r;
  endfunction

  function automatic logic [31:0] to_bcd(input int x);
    logic [31:0] r = '0;
    int t = x;
    for (int i = 0; i < 8; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_now(input string tag);
    chk(tag, "cycles", bcd2int(32'(cycles), 4), m_cyc);
    chk(tag, "phase_int", bcd2int(32'(phase_int), 4), m_pint);
    chk(tag, "residue", bcd2int(32'(residue), 5), m_frac);
  endtask

  // driver: one strobe, expected result pushed to the scoreboard
  task automatic do_frame(input bit ld, input int hz, input string tag);
    int inc_i, inc_f, s, c;
    exp_t e;
    @(negedge clk);
    frame = 1'b1;
    load = ld;
    freq_word = to_bcd(hz);
    if (ld) m_hz = hz;
    inc_i = m_hz / 100000;
    inc_f = m_hz % 100000;
    s = m_frac + inc_f;
    c = (s >= 100000) ? 1 : 0;
    m_frac = s % 100000;
    m_cyc = inc_i + c;
    m_pint = (m_pint + inc_i + c) % 10000;
    e.cyc = m_cyc; e.pint = m_pint; e.frac = m_frac; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    frame = 1'b0;
    load = 1'b0;
  endtask

  // monitor: pop and compare after each strobed edge
  initial begin
    forever begin
      @(posedge clk);
      if (frame && !rst) begin
        exp_t e;
        @(negedge clk);
        if (q.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R2 unexpected update: actual 1 expected 0");
        end else begin
          e = q.pop_front();
          chk(e.tag, "cycles", bcd2int(32'(cycles), 4), e.cyc);
          chk(e.tag, "phase_int", bcd2int(32'(phase_int), 4), e.pint);
          chk(e.tag, "residue", bcd2int(32'(residue), 5), e.frac);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_now("R1");  // reset state

    // R5 R7 R6: 42.123 MHz, fifth frame carries the fraction
    do_frame(1'b1, 42123000, "R5");
    do_frame(1'b0, 0, "R5");
    do_frame(1'b0, 0, "R7");
    do_frame(1'b0, 0, "R7");
    do_frame(1'b0, 0, "R6");

    // R2: idle cycles with a changing word leave outputs alone
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      freq_word = to_bcd(55555555 + i);
    end
    @(negedge clk);
    check_now("R2");

    // R4: load without frame ignored
    @(negedge clk);
    load = 1'b1;
    freq_word = to_bcd(70000000);
    @(negedge clk);
    load = 1'b0;
    check_now("R4");
    do_frame(1'b0, 69999999, "R4");

    // R6: 42.15 MHz alternates 421/422
    for (int i = 0; i < 4; i++) do_frame(i == 0, 42150000, "R6");

    // R7: 70 MHz wraps the 4-digit phase total
    for (int i = 0; i < 16; i++) do_frame(i == 0, 70000000, "R7");

    // R3: least significant Hz digit
    for (int i = 0; i < 3; i++) do_frame(i == 0, 42000001, "R3");

    // R1: mid-run reset clears phase and the held word
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_hz = 0; m_frac = 0; m_pint = 0; m_cyc = 0;
    check_now("R1");
    do_frame(1'b0, 55000000, "R1");

    // R8 and general: random words across the range
    for (int i = 0; i < 40; i++)
      do_frame((i == 0) || ($urandom_range(1, 0) == 1),
               42000000 + int'($urandom_range(28000000, 0)), "R8");

    repeat (3) @(negedge clk);
    chk("R2", "queue empty", q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule